// File: doc/BRIEF.md
# Gated Parallel-In Serial-Out Register

This block turns a word of parallel input bits into a serial bit stream. While the active-low load control is asserted, the register keeps capturing the parallel word on every system cycle. The serial clock and the enable have no effect during that time. Once load is released, each rising edge of the serial clock moves the word one place toward the serial output, but only while the active-low clock enable is held low. The serial input fills the vacated stage at the far end.

Because the serial input enters behind the data, several registers can be chained. Each register's output is wired to the next register's input. A chain of N registers is read with N times WIDTH serial clock pulses.

The serial clock is treated as an ordinary data input. It is synchronised into the system clock domain, and its rising edge is detected there.

Top module: `gated_piso_top`

## Requirements
- R1: While rstN is low, every stage is set to one, so serOut reads 1 after reset.
- R2: At a system clock edge where loadN is 0, the register takes parIn. From the next cycle serOut equals parIn[WIDTH-1], whatever serClk, clkEnN and serIn are doing.
- R3: Load takes priority over shifting. A serial clock edge detected while loadN is 0 leaves the register holding parIn.
- R4: With loadN 1 and clkEnN 0, a detected rising edge of serClk shifts each stage one place toward serOut. serIn enters stage 0 at the same time. The register changes on the (SYNC_STAGES+1)th system clock edge after serClk is first sampled high.
- R5: With loadN 1 and clkEnN 1, serial clock edges leave the contents, and therefore serOut, unchanged.
- R6: A high level or a falling edge of serClk causes no shift. One rising edge shifts exactly once.
- R7: After a load, serOut presents parIn[WIDTH-1] first, then bits WIDTH-2 down to 0, one per shift.
- R8: After WIDTH consecutive shifts, serOut shows the serIn values that were shifted in. With serIn held at 1, serOut stays at 1.
- R9: When one register's serOut drives the next register's serIn, 2×WIDTH shifts read out the downstream word first, then the upstream word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| parIn | input | WIDTH | Parallel data word |
| loadN | input | 1 | Active-low level-sensitive load |
| serClk | input | 1 | Serial shift clock, sampled in the system domain |
| clkEnN | input | 1 | Active-low shift enable |
| serIn | input | 1 | Serial data entering stage 0 |
| serOut | output | 1 | Serial data from stage WIDTH-1 |

## Verification
The assertions check a set of rules on every cycle. A load strobe must capture the parallel word. A cycle with no strobe must keep the register stable. A shift must move the top stage down and take serIn into stage 0. Shift strobes never come on consecutive cycles, so one serial edge cannot shift twice. Some behaviours can only be shown by the bench's scenarios, where a behavioural model follows every system clock. These are the exact latency from a serial edge to the shift, the MSB-first order of a whole word, the fill of serIn after a full readout, and the readout of a two-register chain.

// File: rtl/gated_piso_pkg.sv
package gated_piso_pkg;
  typedef struct packed {
    logic load;
    logic shift;
  } piso_strobe_t;
endpackage

// File: rtl/gated_piso_ctrl.sv
module gated_piso_ctrl
  import gated_piso_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         loadN,
  input  logic         serClk,
  input  logic         clkEnN,
  output piso_strobe_t strb
);
  localparam int LastStage = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   prevQ;
  logic                   riseDet;

  generate
    if (SYNC_STAGES == 1) begin : g_sync_one
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= serClk;
      end
    end else begin : g_sync_many
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], serClk};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevQ <= 1'b0;
    else       prevQ <= syncQ[LastStage];
  end

  assign riseDet = syncQ[LastStage] & ~prevQ;

  always_comb begin
    strb.load  = ~loadN;
    strb.shift = loadN & ~clkEnN & riseDet;
  end

  // R6: one rising serial edge yields a single shift strobe
  p_single_edge_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.shift |=> !strb.shift);
endmodule

// File: rtl/gated_piso_datapath.sv
module gated_piso_datapath
  import gated_piso_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  piso_strobe_t     strb,
  input  logic [WIDTH-1:0] parIn,
  input  logic             serIn,
  output logic             serOut
);
  localparam int TopBit = WIDTH - 1;

  logic [WIDTH-1:0] dataQ;
  logic [WIDTH-1:0] dataNext;

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
      logic feedBit;
      if (i == 0) begin : g_first
        assign feedBit = serIn;
      end else begin : g_rest
        assign feedBit = dataQ[i-1];
      end
      always_comb begin
        if (strb.load)       dataNext[i] = parIn[i];
        else if (strb.shift) dataNext[i] = feedBit;
        else                 dataNext[i] = dataQ[i];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dataQ <= '1;
    else       dataQ <= dataNext;
  end

  assign serOut = dataQ[TopBit];

  p_load_capture_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> dataQ == $past(parIn));
  p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.load && !strb.shift) |=> $stable(dataQ));
  p_fill_serin_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.shift && !strb.load) |=> dataQ[0] == $past(serIn));
  p_toward_out_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.shift && !strb.load) |=> dataQ[TopBit] == $past(dataQ[TopBit-1]));
endmodule

// File: rtl/gated_piso_top.sv
module gated_piso_top
  import gated_piso_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] parIn,
  input  logic             loadN,
  input  logic             serClk,
  input  logic             clkEnN,
  input  logic             serIn,
  output logic             serOut
);
  piso_strobe_t strb;

  gated_piso_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .loadN(loadN), .serClk(serClk),
    .clkEnN(clkEnN), .strb(strb)
  );

  gated_piso_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .parIn(parIn),
    .serIn(serIn), .serOut(serOut)
  );

  // R1: reset leaves the output at one
  p_reset_ones_r1: assert property (@(posedge clk)
    $rose(rstN) |-> serOut == 1'b1);
endmodule

// File: tb/tb_gated_piso_top.sv
module tb_gated_piso_top;
  localparam int CLK_PERIOD  = 10;
  localparam int WIDTH       = 8;
  localparam int SYNC_STAGES = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [WIDTH-1:0] parIn = '0;
  logic [WIDTH-1:0] parIn2 = '0;
  logic loadN = 1'b1, serClk = 1'b0, clkEnN = 1'b1, serIn = 1'b1;
  logic serOut, serOut2;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gated_piso_top #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) dut (
    .clk(clk), .rstN(rstN), .parIn(parIn), .loadN(loadN), .serClk(serClk),
    .clkEnN(clkEnN), .serIn(serIn), .serOut(serOut)
  );

  gated_piso_top #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) dut2 (
    .clk(clk), .rstN(rstN), .parIn(parIn2), .loadN(loadN), .serClk(serClk),
    .clkEnN(clkEnN), .serIn(serOut), .serOut(serOut2)
  );

  // behavioural reference for dut: list of bits, index 0 is the output end
  bit modelBits[$];
  bit clkHist[$];

  task automatic modelReset();
    modelBits = {};
    clkHist = {};
    for (int i = 0; i < WIDTH; i++) modelBits.push_back(1'b1);
    for (int i = 0; i <= SYNC_STAGES; i++) clkHist.push_back(1'b0);
  endtask

  initial modelReset();

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modelReset();
    end else begin
      bit edgeSeen;
      edgeSeen = clkHist[SYNC_STAGES-1] && !clkHist[SYNC_STAGES];
      if (!loadN) begin
        modelBits = {};
        for (int i = WIDTH-1; i >= 0; i--) modelBits.push_back(parIn[i]);
      end else if (!clkEnN && edgeSeen) begin
        void'(modelBits.pop_front());
        modelBits.push_back(serIn);
      end
      clkHist.push_front(serClk);
      void'(clkHist.pop_back());
    end
  end

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the model (R4 timing)
  always @(negedge clk) begin
    if (rstN && !done) check("R4 model", serOut, modelBits[0]);
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse();
    serClk = 1'b1; cyc(5);
    serClk = 1'b0; cyc(5);
  endtask

  task automatic loadWord(input logic [WIDTH-1:0] w, input logic [WIDTH-1:0] w2);
    parIn = w; parIn2 = w2; loadN = 1'b0; cyc(2);
    loadN = 1'b1; cyc(1);
  endtask

  initial begin
    cyc(3);
    check("R1 reset", serOut, 1'b1);
    rstN = 1'b1; cyc(2);
    check("R1 after reset", serOut, 1'b1);

    // R2: load with toggling clock and enable
    parIn = 8'h35; loadN = 1'b0; clkEnN = 1'b0; serIn = 1'b0;
    serClk = 1'b1; cyc(4); serClk = 1'b0; cyc(4);
    check("R2 load msb low", serOut, 1'b0);
    parIn = 8'hB5; cyc(1);
    check("R2 follows parIn", serOut, 1'b1);
    // R3: edge during load does not shift
    serClk = 1'b1; cyc(5); serClk = 1'b0; cyc(5);
    check("R3 load priority", serOut, 1'b1);
    loadN = 1'b1; cyc(1);

    // R7/R4: MSB first readout of 8'hB5, serIn pattern 0,1,0,...
    begin
      logic [WIDTH-1:0] w;
      w = 8'hB5;
      check("R7 bit7", serOut, w[7]);
      for (int k = 1; k < WIDTH; k++) begin
        serIn = k[0];
        pulse();
        check("R7 bit order", serOut, w[WIDTH-1-k]);
      end
      serIn = 1'b0; pulse();
      // serIn values shifted in: k=1..7 -> 1,0,1,0,1,0,1 then 0
      check("R8 fill first", serOut, 1'b1);
    end

    // R4 exact latency: the register changes on the (SYNC_STAGES+1)th edge
    loadWord(8'h80, 8'h00);
    serIn = 1'b0; serClk = 1'b1;
    cyc(SYNC_STAGES);
    check("R4 not yet", serOut, 1'b1);
    cyc(1);
    check("R4 shifted", serOut, 1'b0);
    serClk = 1'b0; cyc(4);

    // R5: enable high blocks shifting
    loadWord(8'hC3, 8'h00);
    clkEnN = 1'b1;
    for (int k = 0; k < 3; k++) pulse();
    check("R5 hold msb", serOut, 1'b1);
    clkEnN = 1'b0; pulse();
    check("R5 resume", serOut, 1'b1);
    pulse();
    check("R5 resume bit5", serOut, 1'b0);

    // R6: held high clock shifts once only
    loadWord(8'hA0, 8'h00);
    serClk = 1'b1; cyc(20);
    check("R6 single shift", serOut, 1'b0);
    serClk = 1'b0; cyc(20);
    check("R6 falling no shift", serOut, 1'b0);

    // R8: serIn held high gives ones after WIDTH shifts
    loadWord(8'h00, 8'h00);
    serIn = 1'b1;
    for (int k = 0; k < WIDTH; k++) pulse();
    check("R8 ones", serOut, 1'b1);
    pulse();
    check("R8 stays one", serOut, 1'b1);

    // R9: two-register chain
    loadWord(8'h4E, 8'hD2);
    serIn = 1'b1;
    begin
      logic [2*WIDTH-1:0] chainWord;
      chainWord = {8'hD2, 8'h4E};
      for (int k = 0; k < 2*WIDTH; k++) begin
        check("R9 chain", serOut2, chainWord[2*WIDTH-1-k]);
        pulse();
      end
      check("R9 chain tail", serOut2, 1'b1);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      failures++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule